// File: doc/BRIEF.md
# Microprogram Sequencer with Jump-Type Next-Address Logic

This block is the control half of a microcoded processor. It keeps a micro-program counter (uPC) that addresses an internal control store, and each word of that store holds a 17-bit datapath control field, a 3-bit jump type and an absolute target micro-address. The next uPC is not stored in every word. It comes from one of six jump types. NEXT steps to the following word. SPIN waits while memory is busy. FETCH returns to the instruction-fetch routine. DISPATCH enters the routine for the macro-opcode's operation group. COND_EQZ and COND_NEZ branch on the datapath zero flag.

The control word leaves the block in a register that is loaded together with the uPC, so `ctrl_o` always belongs to the address shown on `upc_o`. The store holds 42 words. The fetch routine (FETCH0 at address 0 through FETCH3) is followed by one routine for each group: ALU register, ALU immediate, load, store, jump, jump register, jump-and-link, jump-and-link register, branch-if-zero, branch-if-nonzero, and an illegal-opcode stub. The datapath sits outside this block. It returns the zero flag and the memory busy signal, and it supplies the opcode from its instruction register.

Top module: `useq_top`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after `rst_i` is sampled high, `upc_o` is 0 and `ctrl_o` is the word at address 0, which has bit 3 (load memory address) set and bit 0 (load instruction register) clear.
- R2: For a word of jump type NEXT, the uPC after the clock edge is the current uPC plus one. For example, the ALU-register routine runs 4, 5, 6.
- R3: For a word of jump type SPIN, the uPC and `ctrl_o` hold while `busy_i` is high. The uPC moves to the current uPC plus one on the first edge where `busy_i` is low.
- R4: For a word of jump type FETCH, the next uPC is 0, the entry of the fetch routine. Every routine ends this way.
- R5: At DISPATCH (address 3), the next uPC depends on the opcode's group. Opcode 0x00 (ALU reg) goes to 4. Opcodes 0x08–0x0F (ALU imm) go to 7. Opcode 0x23 (load) goes to 10, and 0x2B (store) goes to 15. Opcodes 0x02 (jump) → 20, 0x06 (jump reg) → 23, 0x03 (jump-link) → 25, 0x07 (jump-link reg) → 29. Opcodes 0x04 (branch-if-zero) → 33 and 0x05 (branch-if-nonzero) → 37.
- R6: A COND_EQZ word jumps to its target when `zero_i` is high and otherwise goes to the current uPC plus one. The branch-if-nonzero entry at 37 uses a target of 0, so it goes to 0 when zero is high and to 38 when zero is low.
- R7: A COND_NEZ word does the reverse. The branch-if-zero entry at 33 goes to 34 when `zero_i` is high and to 0 when it is low.
- R8: The fetch routine is four words. Word 0 is NEXT. Word 1 is SPIN and has bit 0 (load instruction register) and bit 7 (memory enable) set. Word 2 is NEXT with bit 1 (load A) set. Word 3 is DISPATCH.
- R9: The load routine runs 10, 11, 12, 13. It spins at 13 while busy is high, then goes to 14 and then to 0.
- R10: Any opcode outside the R5 list dispatches to address 41, and the next step goes to 0.
- R11: `busy_i` and `zero_i` have no effect in words that do not test them. A high busy at address 0 still gives 1, and a high zero during the ALU routine still gives 5 and then 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Macro-opcode from the instruction register |
| zero_i | input | 1 | Zero flag from the datapath |
| busy_i | input | 1 | Memory busy |
| upc_o | output | 6 | Current micro-address |
| ctrl_o | output | 17 | Registered control word for the current micro-address |

## Verification
The fetch routine is run with no busy cycles and with several busy cycles. This shows whether SPIN holds both the address and the control word, or steps past the memory wait. Each opcode group is dispatched once, along with one opcode outside the list, so a wrong group decode or a wrong entry address shows up as a wrong landing address. Both branch routines are driven with zero high and with zero low, which separates the two conditional jump types from each other and from NEXT. Busy and zero are also raised in words that ignore them, to show that only the SPIN and conditional words look at them.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [2:0] {
        JT_NEXT     = 3'd0,
        JT_SPIN     = 3'd1,
        JT_FETCH    = 3'd2,
        JT_DISPATCH = 3'd3,
        JT_COND_EQZ = 3'd4,
        JT_COND_NEZ = 3'd5
    } jump_e;

    typedef enum logic [3:0] {
        GRP_ALU_REG,
        GRP_ALU_IMM,
        GRP_LOAD,
        GRP_STORE,
        GRP_JUMP,
        GRP_JUMP_REG,
        GRP_JUMP_LINK,
        GRP_JUMP_LINK_REG,
        GRP_BR_ZERO,
        GRP_BR_NONZERO,
        GRP_ILLEGAL
    } group_e;

    localparam int CW = 17;

    // single-bit strobes
    localparam logic [CW-1:0] C_LD_IR  = CW'(1) << 0;
    localparam logic [CW-1:0] C_LD_A   = CW'(1) << 1;
    localparam logic [CW-1:0] C_LD_B   = CW'(1) << 2;
    localparam logic [CW-1:0] C_LD_MA  = CW'(1) << 3;
    localparam logic [CW-1:0] C_REG_WR = CW'(1) << 4;
    localparam logic [CW-1:0] C_EN_REG = CW'(1) << 5;
    localparam logic [CW-1:0] C_MEM_WR = CW'(1) << 6;
    localparam logic [CW-1:0] C_EN_MEM = CW'(1) << 7;
    localparam logic [CW-1:0] C_EN_ALU = CW'(1) << 8;
    localparam logic [CW-1:0] C_EN_IMM = CW'(1) << 9;

    // register select, bits 12:10
    localparam logic [CW-1:0] RS_RS   = CW'(0) << 10;
    localparam logic [CW-1:0] RS_RT   = CW'(1) << 10;
    localparam logic [CW-1:0] RS_RD   = CW'(2) << 10;
    localparam logic [CW-1:0] RS_PC   = CW'(3) << 10;
    localparam logic [CW-1:0] RS_LINK = CW'(4) << 10;

    // immediate extension, bits 14:13
    localparam logic [CW-1:0] EX_SIGN = CW'(0) << 13;
    localparam logic [CW-1:0] EX_ZERO = CW'(1) << 13;
    localparam logic [CW-1:0] EX_JUMP = CW'(2) << 13;
    localparam logic [CW-1:0] EX_FOUR = CW'(3) << 13;

    // ALU operation, bits 16:15
    localparam logic [CW-1:0] OP_ADD   = CW'(0) << 15;
    localparam logic [CW-1:0] OP_PASSA = CW'(1) << 15;
    localparam logic [CW-1:0] OP_FUNC  = CW'(2) << 15;
    localparam logic [CW-1:0] OP_JTARG = CW'(3) << 15;

endpackage

// File: rtl/useq_opgroup.sv
module useq_opgroup
    import useq_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] opcode_i,
    output group_e          grp_o
);
    always_comb begin
        grp_o = GRP_ILLEGAL;
        casez (opcode_i)
            6'b000000: grp_o = GRP_ALU_REG;
            6'b001???: grp_o = GRP_ALU_IMM;
            6'b100011: grp_o = GRP_LOAD;
            6'b101011: grp_o = GRP_STORE;
            6'b000010: grp_o = GRP_JUMP;
            6'b000011: grp_o = GRP_JUMP_LINK;
            6'b000100: grp_o = GRP_BR_ZERO;
            6'b000101: grp_o = GRP_BR_NONZERO;
            6'b000110: grp_o = GRP_JUMP_REG;
            6'b000111: grp_o = GRP_JUMP_LINK_REG;
            default:   grp_o = GRP_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int UPC_W  = 6,
    parameter int CTRL_W = 17
) (
    input  logic [UPC_W-1:0]  addr_i,
    input  group_e            grp_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output jump_e             jt_o,
    output logic [UPC_W-1:0]  tgt_o,
    output logic [UPC_W-1:0]  entry_o
);
    localparam logic [UPC_W-1:0] FETCH_ENTRY = '0;

    logic [CW-1:0] cw;

    // control store: one row per micro-step
    always_comb begin
        cw    = '0;
        jt_o  = JT_FETCH;
        tgt_o = FETCH_ENTRY;
        unique case (int'(addr_i))
            // instruction fetch
            0:  begin cw = C_LD_MA | C_EN_REG | RS_PC;                jt_o = JT_NEXT;     end
            1:  begin cw = C_LD_IR | C_EN_MEM;                        jt_o = JT_SPIN;     end
            2:  begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            3:  begin cw = C_REG_WR | C_EN_ALU | RS_PC | EX_FOUR | OP_ADD; jt_o = JT_DISPATCH; end
            // ALU register
            4:  begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            5:  begin cw = C_LD_B | C_EN_REG | RS_RT;                 jt_o = JT_NEXT;     end
            6:  begin cw = C_REG_WR | C_EN_ALU | RS_RD | OP_FUNC;     jt_o = JT_FETCH;    end
            // ALU immediate
            7:  begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            8:  begin cw = C_LD_B | C_EN_IMM | EX_SIGN;               jt_o = JT_NEXT;     end
            9:  begin cw = C_REG_WR | C_EN_ALU | RS_RT | OP_FUNC;     jt_o = JT_FETCH;    end
            // load
            10: begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            11: begin cw = C_LD_B | C_EN_IMM | EX_SIGN;               jt_o = JT_NEXT;     end
            12: begin cw = C_LD_MA | C_EN_ALU | OP_ADD;               jt_o = JT_NEXT;     end
            13: begin cw = C_REG_WR | C_EN_MEM | RS_RT;               jt_o = JT_SPIN;     end
            14: begin cw = '0;                                        jt_o = JT_FETCH;    end
            // store
            15: begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            16: begin cw = C_LD_B | C_EN_IMM | EX_SIGN;               jt_o = JT_NEXT;     end
            17: begin cw = C_LD_MA | C_EN_ALU | OP_ADD;               jt_o = JT_NEXT;     end
            18: begin cw = C_MEM_WR | C_EN_REG | RS_RT;               jt_o = JT_SPIN;     end
            19: begin cw = '0;                                        jt_o = JT_FETCH;    end
            // jump
            20: begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            21: begin cw = C_LD_B | C_EN_IMM | EX_JUMP;               jt_o = JT_NEXT;     end
            22: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_JTARG;    jt_o = JT_FETCH;    end
            // jump register
            23: begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            24: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_PASSA;    jt_o = JT_FETCH;    end
            // jump and link
            25: begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            26: begin cw = C_REG_WR | C_EN_ALU | RS_LINK | OP_PASSA;  jt_o = JT_NEXT;     end
            27: begin cw = C_LD_B | C_EN_IMM | EX_JUMP;               jt_o = JT_NEXT;     end
            28: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_JTARG;    jt_o = JT_FETCH;    end
            // jump and link register
            29: begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            30: begin cw = C_LD_B | C_EN_REG | RS_RS;                 jt_o = JT_NEXT;     end
            31: begin cw = C_REG_WR | C_EN_ALU | RS_LINK | OP_PASSA;  jt_o = JT_NEXT;     end
            32: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_FUNC;     jt_o = JT_FETCH;    end
            // branch if zero: fall through when zero, else refetch
            33: begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_COND_NEZ; end
            34: begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            35: begin cw = C_LD_B | C_EN_IMM | EX_SIGN;               jt_o = JT_NEXT;     end
            36: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_ADD;      jt_o = JT_FETCH;    end
            // branch if nonzero: refetch when zero, else fall through
            37: begin cw = C_LD_A | C_EN_REG | RS_RS;                 jt_o = JT_COND_EQZ; end
            38: begin cw = C_LD_A | C_EN_REG | RS_PC;                 jt_o = JT_NEXT;     end
            39: begin cw = C_LD_B | C_EN_IMM | EX_SIGN;               jt_o = JT_NEXT;     end
            40: begin cw = C_REG_WR | C_EN_ALU | RS_PC | OP_ADD;      jt_o = JT_FETCH;    end
            // illegal opcode stub
            default: begin cw = '0;                                   jt_o = JT_FETCH;    end
        endcase
    end

    assign ctrl_o = CTRL_W'(cw);

    // dispatch entry per operation group
    always_comb begin
        unique case (grp_i)
            GRP_ALU_REG:       entry_o = UPC_W'(4);
            GRP_ALU_IMM:       entry_o = UPC_W'(7);
            GRP_LOAD:          entry_o = UPC_W'(10);
            GRP_STORE:         entry_o = UPC_W'(15);
            GRP_JUMP:          entry_o = UPC_W'(20);
            GRP_JUMP_REG:      entry_o = UPC_W'(23);
            GRP_JUMP_LINK:     entry_o = UPC_W'(25);
            GRP_JUMP_LINK_REG: entry_o = UPC_W'(29);
            GRP_BR_ZERO:       entry_o = UPC_W'(33);
            GRP_BR_NONZERO:    entry_o = UPC_W'(37);
            default:           entry_o = UPC_W'(41);
        endcase
    end
endmodule

// File: rtl/useq_nextpc.sv
module useq_nextpc
    import useq_pkg::*;
#(
    parameter int UPC_W = 6
) (
    input  logic [UPC_W-1:0] upc_i,
    input  jump_e            jt_i,
    input  logic [UPC_W-1:0] tgt_i,
    input  logic [UPC_W-1:0] entry_i,
    input  logic             busy_i,
    input  logic             zero_i,
    output logic [UPC_W-1:0] next_o
);
    localparam logic [UPC_W-1:0] STEP = UPC_W'(1);

    logic [UPC_W-1:0] inc;
    assign inc = upc_i + STEP;

    always_comb begin
        unique case (jt_i)
            JT_NEXT:     next_o = inc;
            JT_SPIN:     next_o = busy_i ? upc_i : inc;
            JT_FETCH:    next_o = tgt_i;
            JT_DISPATCH: next_o = entry_i;
            JT_COND_EQZ: next_o = zero_i ? tgt_i : inc;
            JT_COND_NEZ: next_o = zero_i ? inc : tgt_i;
            default:     next_o = tgt_i;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int UPC_W  = 6,
    parameter int OP_W   = 6,
    parameter int CTRL_W = 17
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              zero_i,
    input  logic              busy_i,
    output logic [UPC_W-1:0]  upc_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    logic [UPC_W-1:0]  upc_q, tgt_q, next_upc, sel_upc, rom_tgt, entry;
    logic [CTRL_W-1:0] ctrl_q, rom_ctrl;
    jump_e             jt_q, rom_jt;
    group_e            grp;

    useq_opgroup #(.OP_W(OP_W)) u_grp (
        .opcode_i (opcode_i),
        .grp_o    (grp)
    );

    useq_nextpc #(.UPC_W(UPC_W)) u_next (
        .upc_i   (upc_q),
        .jt_i    (jt_q),
        .tgt_i   (tgt_q),
        .entry_i (entry),
        .busy_i  (busy_i),
        .zero_i  (zero_i),
        .next_o  (next_upc)
    );

    assign sel_upc = rst_i ? '0 : next_upc;

    useq_store #(.UPC_W(UPC_W), .CTRL_W(CTRL_W)) u_store (
        .addr_i  (sel_upc),
        .grp_i   (grp),
        .ctrl_o  (rom_ctrl),
        .jt_o    (rom_jt),
        .tgt_o   (rom_tgt),
        .entry_o (entry)
    );

    // uPC and its control word are loaded together
    always_ff @(posedge clk_i) begin
        upc_q  <= sel_upc;
        ctrl_q <= rom_ctrl;
        jt_q   <= rom_jt;
        tgt_q  <= rom_tgt;
    end

    assign upc_o  = upc_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int UPC_W  = 6,
    parameter int CTRL_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              zero,
    input logic [UPC_W-1:0]  upc,
    input logic [CTRL_W-1:0] ctrl,
    input jump_e             jt,
    input logic [UPC_W-1:0]  tgt
);
    localparam logic [UPC_W-1:0] ONE = UPC_W'(1);

    AST_RESET_ENTRY: assert property (@(posedge clk)
        rst |=> upc == '0); // R1

    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (rst)
        jt == JT_NEXT |=> upc == $past(upc) + ONE); // R2

    AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (jt == JT_SPIN && busy) |=> ($stable(upc) && $stable(ctrl))); // R3

    AST_SPIN_GO: assert property (@(posedge clk) disable iff (rst)
        (jt == JT_SPIN && !busy) |=> upc == $past(upc) + ONE); // R3

    AST_FETCH_RET: assert property (@(posedge clk) disable iff (rst)
        jt == JT_FETCH |=> upc == $past(tgt)); // R4

    AST_EQZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (jt == JT_COND_EQZ && zero) |=> upc == $past(tgt)); // R6

    AST_NEZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (jt == JT_COND_NEZ && !zero) |=> upc == $past(tgt)); // R7
endmodule

bind useq_top useq_chk #(.UPC_W(UPC_W), .CTRL_W(CTRL_W)) u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .busy (busy_i),
    .zero (zero_i),
    .upc  (upc_o),
    .ctrl (ctrl_o),
    .jt   (jt_q),
    .tgt  (tgt_q)
);

// File: tb/tb_useq_top.sv
module tb_useq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic        zero = 1'b0;
    logic        busy = 1'b0;
    logic [5:0]  upc;
    logic [16:0] ctrl;

    int tests = 0;
    int fails = 0;

    useq_top dut (
        .clk_i(clk), .rst_i(rst), .opcode_i(opcode), .zero_i(zero),
        .busy_i(busy), .upc_o(upc), .ctrl_o(ctrl)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; busy = 1'b0; zero = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    // run fetch with nb busy cycles, dispatch op, check entry
    task automatic fetch_dispatch(input logic [5:0] op, input int nb, input int entry, input string tag);
        logic [16:0] held;
        chk(upc, 0, "R4 start at fetch entry");
        busy = 1'b1;                    // R11: ignored at NEXT word
        tick();
        chk(upc, 1, "R11 busy ignored at word 0");
        chk(int'(ctrl[0]), 1, "R8 word1 load-IR bit");
        chk(int'(ctrl[7]), 1, "R8 word1 mem-enable bit");
        held = ctrl;
        for (int i = 0; i < nb; i++) begin
            tick();
            chk(upc, 1, "R3 spin holds uPC");
            chk(int'(ctrl == held), 1, "R3 spin holds ctrl");
        end
        busy = 1'b0;
        tick();
        chk(upc, 2, "R3 spin releases");
        chk(int'(ctrl[1]), 1, "R8 word2 load-A bit");
        tick();
        chk(upc, 3, "R8 word3");
        opcode = op;
        tick();
        chk(upc, entry, tag);
    endtask

    task automatic t_reset();
        do_reset();
        chk(upc, 0, "R1 reset uPC");
        chk(int'(ctrl[3]), 1, "R1 reset ctrl bit3");
        chk(int'(ctrl[0]), 0, "R1 reset ctrl bit0");
    endtask

    task automatic t_alu_reg();
        fetch_dispatch(6'h00, 0, 4, "R5 ALU reg entry");
        zero = 1'b1;
        tick(); chk(upc, 5, "R2 R11 ALU step");
        tick(); chk(upc, 6, "R2 R11 ALU step");
        zero = 1'b0;
        tick(); chk(upc, 0, "R4 ALU returns");
    endtask

    task automatic t_load();
        fetch_dispatch(6'h23, 3, 10, "R5 load entry");
        tick(); chk(upc, 11, "R9 load");
        tick(); chk(upc, 12, "R9 load");
        tick(); chk(upc, 13, "R9 load");
        busy = 1'b1;
        tick(); chk(upc, 13, "R9 load spin");
        tick(); chk(upc, 13, "R9 load spin");
        busy = 1'b0;
        tick(); chk(upc, 14, "R9 load after spin");
        tick(); chk(upc, 0, "R9 R4 load returns");
    endtask

    task automatic t_dispatch_table();
        fetch_dispatch(6'h0B, 1, 7,  "R5 ALU imm entry");  do_reset();
        fetch_dispatch(6'h2B, 0, 15, "R5 store entry");    do_reset();
        fetch_dispatch(6'h02, 0, 20, "R5 jump entry");     do_reset();
        fetch_dispatch(6'h06, 0, 23, "R5 jump reg entry"); do_reset();
        fetch_dispatch(6'h03, 0, 25, "R5 jump link entry"); do_reset();
        fetch_dispatch(6'h07, 2, 29, "R5 jump link reg entry"); do_reset();
    endtask

    task automatic t_br_zero();
        fetch_dispatch(6'h04, 0, 33, "R5 br-zero entry");
        zero = 1'b1;
        tick(); chk(upc, 34, "R7 zero high falls through");
        zero = 1'b0;
        do_reset();
        fetch_dispatch(6'h04, 0, 33, "R5 br-zero entry");
        tick(); chk(upc, 0, "R7 zero low to fetch");
    endtask

    task automatic t_br_nonzero();
        fetch_dispatch(6'h05, 0, 37, "R5 br-nonzero entry");
        zero = 1'b1;
        tick(); chk(upc, 0, "R6 zero high to fetch");
        zero = 1'b0;
        fetch_dispatch(6'h05, 0, 37, "R5 br-nonzero entry");
        tick(); chk(upc, 38, "R6 zero low falls through");
        do_reset();
    endtask

    task automatic t_illegal();
        fetch_dispatch(6'h3F, 0, 41, "R10 illegal entry");
        tick(); chk(upc, 0, "R10 illegal returns");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_alu_reg();
        t_load();
        t_dispatch_table();
        t_br_zero();
        do_reset();
        t_br_nonzero();
        t_illegal();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule